// File: doc/BRIEF.md
# Memory-Mapped Hash DMA Controller

This block is the sequencing logic that sits between a host command port, a byte-wide external memory and a 160-bit digest engine. The host programs a source pointer, a destination pointer, a message length in bytes and a byte-order option through a sixteen-entry register window. It then writes a go value. The controller reads the message from memory one byte per cycle and packs each 64 bytes into a 512-bit block. It hands every block to the engine with a one-cycle start pulse, waits for the engine to report done, and repeats until the byte count reaches the length. It then writes the 20-byte digest to the destination pointer and returns to idle.

The engine itself is outside the block. The bench supplies a simple stand-in for it. The host can poll the state register at any time to see when an operation has finished.

Top module: `hash_dma_ctrl`

## Requirements
- R1: A command is decoded only when host_addr lies in 0xFE00..0xFE0F. host_cmd=1 is a register read and host_cmd=2 is a register write; host_cmd 0 and 3 do nothing. An access outside the window changes no register, and a read outside it leaves host_rdata unchanged.
- R2: The state register at offset 0x1 reads as 0 for idle, 1 for fetch, 2 for engine issue, 3 for engine wait and 4 for digest store. It never takes any other value.
- R3: Register writes take effect only while the state is idle. Writes made in any other state are dropped.
- R4: Writing 0x01 to offset 0x0 while idle moves the state to 1 on the next cycle and clears the bytes-read counter. Any other value written there has no effect.
- R5: Each fetch reads 64 bytes on consecutive cycles, one byte per cycle with mem_rd high, at source + bytes-read + k for k = 0..63 (16-bit wrap). The bytes-read counter then increases by 64. When the order bit is 1, byte k lands in block bits [(63-k)*8 +: 8]. When it is 0, byte k lands in bits [k*8 +: 8].
- R6: In state 2, eng_start is high for exactly one cycle. eng_init is high with it only for the first block of an operation. The controller stays in state 3 until eng_done is seen.
- R7: When eng_done is seen, the next state is 1 if bytes-read < length and 4 otherwise. An operation therefore hashes max(1, ceil(length/64)) blocks.
- R8: In state 4 the 20 digest bytes are written on consecutive cycles to destination + k, k = 0..19. With the order bit at 1, byte k is digest bits [(19-k)*8 +: 8]. With it at 0, byte k is bits [k*8 +: 8]. No other address is written. The state then returns to 0.
- R9: The read map is as follows. Offset 0x1 gives the state, zero-extended. Offsets 0x2/0x3 give the source low/high byte, 0x4/0x5 the destination low/high byte, and 0x6/0x7 the length low/high byte. Bit 0 of offset 0x8 gives the order bit. Offsets 0x0 and 0x9..0xF read as zero. host_rdata updates on the clock edge that samples the read.
- R10: After reset the state is idle, the pointers and length are zero and the order bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd | input | 2 | Host command: 1 read, 2 write |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| mem_addr | output | 16 | External memory byte address |
| mem_rd | output | 1 | Memory read strobe; data is taken the same cycle |
| mem_rdata | input | 8 | Memory read data (combinational) |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| eng_block | output | 512 | Message block to the engine |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_init | output | 1 | First block of an operation |
| eng_done | input | 1 | Engine finished the current block |
| eng_digest | input | 160 | Running digest from the engine |

## Verification
The assertions assume that eng_done is pulsed only after an eng_start, while the controller waits in state 3. They also assume that memory read data is valid in the same cycle as the address. The bench engine stand-in pulses done exactly once, a few cycles after each start. The bench memory is a combinational array. The random operations keep the source and destination regions apart, so a digest store never alters bytes that are still to be fetched.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_ISSUE = 3'd2,
      ST_WAIT  = 3'd3,
      ST_STORE = 3'd4
   } hdc_state_e;

   localparam logic [1:0] CMD_RD = 2'd1;
   localparam logic [1:0] CMD_WR = 2'd2;

   localparam logic [3:0] OFS_GO     = 4'h0;
   localparam logic [3:0] OFS_STATE  = 4'h1;
   localparam logic [3:0] OFS_SRC_LO = 4'h2;
   localparam logic [3:0] OFS_SRC_HI = 4'h3;
   localparam logic [3:0] OFS_DST_LO = 4'h4;
   localparam logic [3:0] OFS_DST_HI = 4'h5;
   localparam logic [3:0] OFS_LEN_LO = 4'h6;
   localparam logic [3:0] OFS_LEN_HI = 4'h7;
   localparam logic [3:0] OFS_CFG    = 4'h8;
endpackage

// File: rtl/hdc_host_regs.sv
module hdc_host_regs
   import hdc_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          LEN_W    = 16,
   parameter logic [15:0] WIN_BASE = 16'hFE00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_cmd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   input  logic              idle,
   input  logic [2:0]        state_in,
   output logic [ADDR_W-1:0] src_base,
   output logic [ADDR_W-1:0] dst_base,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              big_endian,
   output logic              go,
   output logic [7:0]        host_rdata
);
   localparam int OFS_W = 4;

   if (ADDR_W != 16) begin : g_bad_addr
      $error("hdc_host_regs: ADDR_W must be 16");
   end
   if (LEN_W != 16) begin : g_bad_len
      $error("hdc_host_regs: LEN_W must be 16");
   end
   if (WIN_BASE[OFS_W-1:0] != '0) begin : g_bad_base
      $error("hdc_host_regs: WIN_BASE must be 16-entry aligned");
   end

   logic             hit;
   logic [OFS_W-1:0] ofs;
   logic             wr_ok;
   logic [7:0]       rd_val;

   assign hit   = (host_addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
   assign ofs   = host_addr[OFS_W-1:0];
   assign wr_ok = hit && (host_cmd == CMD_WR) && idle;
   assign go    = wr_ok && (ofs == OFS_GO) && (host_wdata == 8'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_base   <= '0;
         dst_base   <= '0;
         xfer_len   <= '0;
         big_endian <= 1'b1;
      end else if (wr_ok) begin
         case (ofs)
            OFS_SRC_LO: src_base[7:0]  <= host_wdata;
            OFS_SRC_HI: src_base[15:8] <= host_wdata;
            OFS_DST_LO: dst_base[7:0]  <= host_wdata;
            OFS_DST_HI: dst_base[15:8] <= host_wdata;
            OFS_LEN_LO: xfer_len[7:0]  <= host_wdata;
            OFS_LEN_HI: xfer_len[15:8] <= host_wdata;
            OFS_CFG:    big_endian     <= host_wdata[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (ofs)
         OFS_STATE:  rd_val = {5'd0, state_in};
         OFS_SRC_LO: rd_val = src_base[7:0];
         OFS_SRC_HI: rd_val = src_base[15:8];
         OFS_DST_LO: rd_val = dst_base[7:0];
         OFS_DST_HI: rd_val = dst_base[15:8];
         OFS_LEN_LO: rd_val = xfer_len[7:0];
         OFS_LEN_HI: rd_val = xfer_len[15:8];
         OFS_CFG:    rd_val = {7'd0, big_endian};
         default:    rd_val = 8'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           host_rdata <= 8'd0;
      else if (hit && host_cmd == CMD_RD)   host_rdata <= rd_val;
   end
endmodule

// File: rtl/hdc_seq.sv
module hdc_seq
   import hdc_pkg::*;
#(
   parameter int BLK_BYTES = 64,
   parameter int DIG_BYTES = 20,
   parameter int LEN_W     = 16,
   parameter int IDX_W     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             eng_done,
   output logic [2:0]       state,
   output logic [IDX_W-1:0] idx,
   output logic [LEN_W:0]   bytes_read,
   output logic             fetch_en,
   output logic             store_en,
   output logic             eng_start,
   output logic             eng_init,
   output logic             dig_cap
);
   localparam logic [IDX_W-1:0] BLK_LAST = IDX_W'(BLK_BYTES - 1);
   localparam logic [IDX_W-1:0] DIG_LAST = IDX_W'(DIG_BYTES - 1);
   localparam logic [LEN_W:0]   BLK_STEP = (LEN_W+1)'(BLK_BYTES);

   if ((1 << IDX_W) < BLK_BYTES || (1 << IDX_W) < DIG_BYTES) begin : g_bad_idx
      $error("hdc_seq: IDX_W too narrow");
   end

   hdc_state_e st_q;
   logic       first_q;

   assign state     = st_q;
   assign fetch_en  = (st_q == ST_FETCH);
   assign store_en  = (st_q == ST_STORE);
   assign eng_start = (st_q == ST_ISSUE);
   assign eng_init  = (st_q == ST_ISSUE) && first_q;
   assign dig_cap   = (st_q == ST_WAIT) && eng_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         idx        <= '0;
         bytes_read <= '0;
         first_q    <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (go) begin
               st_q       <= ST_FETCH;
               idx        <= '0;
               bytes_read <= '0;
               first_q    <= 1'b1;
            end
            ST_FETCH: begin
               if (idx == BLK_LAST) begin
                  idx        <= '0;
                  bytes_read <= bytes_read + BLK_STEP;
                  st_q       <= ST_ISSUE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (eng_done) begin
               first_q <= 1'b0;
               st_q    <= (bytes_read < {1'b0, xfer_len}) ? ST_FETCH : ST_STORE;
            end
            ST_STORE: begin
               if (idx == DIG_LAST) begin
                  idx  <= '0;
                  st_q <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hdc_lanes.sv
module hdc_lanes #(
   parameter int BLK_BYTES = 64,
   parameter int DIG_BYTES = 20,
   parameter int IDX_W     = 6,
   localparam int BLK_W    = BLK_BYTES * 8,
   localparam int DIG_W    = DIG_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [IDX_W-1:0] idx,
   input  logic             big_endian,
   input  logic [7:0]       byte_in,
   input  logic             dig_cap,
   input  logic [DIG_W-1:0] dig_in,
   output logic [BLK_W-1:0] block,
   output logic [7:0]       byte_out
);
   logic [7:0]       lane_q [BLK_BYTES];
   logic [DIG_W-1:0] dig_q;
   logic [IDX_W-1:0] sel;

   for (genvar j = 0; j < BLK_BYTES; j++) begin : g_lane
      localparam logic [IDX_W-1:0] POS_BIG = IDX_W'(BLK_BYTES - 1 - j);
      localparam logic [IDX_W-1:0] POS_LIT = IDX_W'(j);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[j] <= 8'd0;
         else if (load_en && idx == (big_endian ? POS_BIG : POS_LIT))
            lane_q[j] <= byte_in;
      end
      assign block[j*8 +: 8] = lane_q[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dig_q <= '0;
      else if (dig_cap) dig_q <= dig_in;
   end

   assign sel      = big_endian ? IDX_W'(DIG_BYTES - 1) - idx : idx;
   assign byte_out = dig_q[sel*8 +: 8];
endmodule

// File: rtl/hash_dma_ctrl.sv
module hash_dma_ctrl
   import hdc_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          LEN_W     = 16,
   parameter int          BLK_BYTES = 64,
   parameter int          DIG_BYTES = 20,
   parameter logic [15:0] WIN_BASE  = 16'hFE00,
   localparam int BLK_W = BLK_BYTES * 8,
   localparam int DIG_W = DIG_BYTES * 8,
   localparam int IDX_W = $clog2(BLK_BYTES > DIG_BYTES ? BLK_BYTES : DIG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_cmd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [7:0]        mem_rdata,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic [BLK_W-1:0]  eng_block,
   output logic              eng_start,
   output logic              eng_init,
   input  logic              eng_done,
   input  logic [DIG_W-1:0]  eng_digest
);
   if (BLK_BYTES & (BLK_BYTES - 1)) begin : g_bad_blk
      $error("hash_dma_ctrl: BLK_BYTES must be a power of two");
   end

   logic [2:0]        state;
   logic [IDX_W-1:0]  idx;
   logic [LEN_W:0]    bytes_read;
   logic [ADDR_W-1:0] src_base, dst_base;
   logic [LEN_W-1:0]  xfer_len;
   logic              big_endian, go, fetch_en, store_en, dig_cap;

   hdc_host_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIN_BASE(WIN_BASE)) u_regs (
      .clk, .rst_n, .host_cmd, .host_addr, .host_wdata,
      .idle(state == 3'd0), .state_in(state),
      .src_base, .dst_base, .xfer_len, .big_endian, .go, .host_rdata
   );

   hdc_seq #(.BLK_BYTES(BLK_BYTES), .DIG_BYTES(DIG_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
      .clk, .rst_n, .go, .xfer_len, .eng_done, .state, .idx, .bytes_read,
      .fetch_en, .store_en, .eng_start, .eng_init, .dig_cap
   );

   hdc_lanes #(.BLK_BYTES(BLK_BYTES), .DIG_BYTES(DIG_BYTES), .IDX_W(IDX_W)) u_lanes (
      .clk, .rst_n, .load_en(fetch_en), .idx, .big_endian, .byte_in(mem_rdata),
      .dig_cap, .dig_in(eng_digest), .block(eng_block), .byte_out(mem_wdata)
   );

   assign mem_rd   = fetch_en;
   assign mem_wr   = store_en;
   assign mem_addr = fetch_en ? src_base + bytes_read[ADDR_W-1:0] + ADDR_W'(idx)
                              : dst_base + ADDR_W'(idx);
endmodule

// File: rtl/hdc_checker.sv
module hdc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  state,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic        eng_start,
   input logic        eng_init,
   input logic        eng_done,
   input logic [15:0] src_base,
   input logic [15:0] dst_base,
   input logic [15:0] xfer_len
);
   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      state <= 3'd4);                                                    // R2
   AST_BUSY_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 3'd0) |=> ($stable(src_base) && $stable(dst_base) && $stable(xfer_len))); // R3
   AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (state == 3'd1 && !mem_wr));                            // R5
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> (!eng_start && state == 3'd3));                      // R6
   AST_INIT_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
      eng_init |-> eng_start);                                           // R6
   AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd3 && eng_done) |=> (state == 3'd1 || state == 3'd4)); // R7
   AST_WRITE_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (state == 3'd4));                                       // R8
endmodule

bind hash_dma_ctrl hdc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .eng_start(eng_start), .eng_init(eng_init), .eng_done(eng_done),
   .src_base(src_base), .dst_base(dst_base), .xfer_len(xfer_len)
);

// File: tb/hash_dma_ctrl_tb.sv
module hash_dma_ctrl_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   host_cmd = 2'd0;
   logic [15:0]  host_addr = 16'd0;
   logic [7:0]   host_wdata = 8'd0;
   logic [7:0]   host_rdata;
   logic [15:0]  mem_addr;
   logic         mem_rd, mem_wr;
   logic [7:0]   mem_rdata, mem_wdata;
   logic [511:0] eng_block;
   logic         eng_start, eng_init;
   logic         eng_done = 1'b0;
   logic [159:0] eng_digest = '0;

   logic [7:0]   mem [4096];
   int           vectors = 0;
   int           errors = 0;
   int           cycles = 0;

   // operation context used by the engine stand-in
   logic [15:0]  cur_src;
   logic         cur_big;
   int           blk_cnt = 0;
   int           init_cnt = 0;
   logic [159:0] exp_dig = '0;
   int           pend = 0;

   always #10 clk = ~clk;

   hash_dma_ctrl u_dut (
      .clk, .rst_n, .host_cmd, .host_addr, .host_wdata, .host_rdata,
      .mem_addr, .mem_rd, .mem_rdata, .mem_wr, .mem_wdata,
      .eng_block, .eng_start, .eng_init, .eng_done, .eng_digest
   );

   assign mem_rdata = mem[mem_addr[11:0]];

   function automatic logic [159:0] mix(input logic [159:0] d, input logic [511:0] b);
      return {d[158:0], d[159]} ^ b[159:0] ^ b[319:160] ^ b[479:320] ^ {128'd0, b[511:480]};
   endfunction

   function automatic logic [511:0] model_block(input logic [15:0] base, input logic big);
      logic [511:0] b;
      for (int k = 0; k < 64; k++) begin
         logic [15:0] a;
         a = base + 16'(k);
         if (big) b[(63-k)*8 +: 8] = mem[a[11:0]];
         else     b[k*8 +: 8]      = mem[a[11:0]];
      end
      return b;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // memory write port and engine stand-in, both on the falling edge
   always @(negedge clk) begin
      cycles++;
      if (mem_wr) mem[mem_addr[11:0]] = mem_wdata;
      eng_done = 1'b0;
      if (pend > 0) begin
         pend--;
         if (pend == 0) eng_done = 1'b1;
      end
      if (eng_start) begin
         logic [511:0] mb;
         mb = model_block(cur_src + 16'(blk_cnt * 64), cur_big);
         vectors++;
         if (mb !== eng_block) begin
            errors++;
            $display("FAIL R5 block %0d: actual 0x%0h expected 0x%0h", blk_cnt, eng_block, mb);
         end
         chk("R6", "init flag", 32'(eng_init), 32'(blk_cnt == 0));
         if (eng_init) init_cnt++;
         eng_digest = mix(eng_init ? 160'd0 : eng_digest, eng_block);
         exp_dig    = mix(blk_cnt == 0 ? 160'd0 : exp_dig, mb);
         blk_cnt++;
         pend = 3;
      end
   end

   task automatic host_op(input logic [1:0] c, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      host_cmd = c; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_cmd = 2'd0;
   endtask

   task automatic reg_wr(input logic [3:0] ofs, input logic [7:0] d);
      host_op(2'd2, {12'hFE0, ofs}, d);
   endtask

   task automatic reg_rd(input logic [3:0] ofs, output logic [7:0] v);
      host_op(2'd1, {12'hFE0, ofs}, 8'd0);
      v = host_rdata;
   endtask

   task automatic run_op(input logic [15:0] src, input logic [15:0] dst,
                         input logic [15:0] len, input logic big, input logic poke_busy);
      logic [7:0]   v;
      logic [7:0]   sentinel;
      logic [159:0] d;
      int           nblk, polls;
      reg_wr(4'h2, src[7:0]);  reg_wr(4'h3, src[15:8]);
      reg_wr(4'h4, dst[7:0]);  reg_wr(4'h5, dst[15:8]);
      reg_wr(4'h6, len[7:0]);  reg_wr(4'h7, len[15:8]);
      reg_wr(4'h8, {7'd0, big});
      sentinel = 8'hC3;
      mem[(dst + 16'd20) & 16'hFFF] = sentinel;
      cur_src = src; cur_big = big; blk_cnt = 0; init_cnt = 0;
      reg_wr(4'h0, 8'h01);
      reg_rd(4'h1, v);
      chk("R4", "state after go", 32'(v), 32'd1);
      if (poke_busy) begin
         reg_wr(4'h2, ~src[7:0]);
         reg_wr(4'h0, 8'h01);
      end
      polls = 0;
      do begin
         reg_rd(4'h1, v);
         polls++;
         if (v != 8'd0 && v > 8'd4) chk("R2", "state range", 32'(v), 32'd4);
      end while (v != 8'd0 && polls < 4000);
      chk("R2", "returned to idle", 32'(v), 32'd0);
      nblk = (len == 0) ? 1 : (int'(len) + 63) / 64;
      chk("R7", "block count", 32'(blk_cnt), 32'(nblk));
      chk("R6", "init pulses", 32'(init_cnt), 32'd1);
      d = exp_dig;
      for (int k = 0; k < 20; k++) begin
         logic [7:0]  e;
         logic [15:0] a;
         a = dst + 16'(k);
         e = big ? d[(19-k)*8 +: 8] : d[k*8 +: 8];
         chk("R8", $sformatf("digest byte %0d", k), 32'(mem[a[11:0]]), 32'(e));
      end
      chk("R8", "byte after digest untouched", 32'(mem[(dst + 16'd20) & 16'hFFF]), 32'(sentinel));
      if (poke_busy) begin
         reg_rd(4'h2, v);
         chk("R3", "busy write dropped", 32'(v), 32'(src[7:0]));
      end
   endtask

   initial begin
      logic [7:0] v;
      int         dummy;
      dummy = $urandom(32'h5EED_1234);
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7) ^ 8'(i >> 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset values
      reg_rd(4'h1, v); chk("R10", "state", 32'(v), 32'd0);
      reg_rd(4'h3, v); chk("R10", "src hi", 32'(v), 32'd0);
      reg_rd(4'h7, v); chk("R10", "len hi", 32'(v), 32'd0);
      reg_rd(4'h8, v); chk("R10", "order bit", 32'(v), 32'd1);

      // read map
      reg_wr(4'h4, 8'hA5); reg_wr(4'h5, 8'h3C); reg_wr(4'h6, 8'h81);
      reg_rd(4'h4, v); chk("R9", "dst lo", 32'(v), 32'hA5);
      reg_rd(4'h5, v); chk("R9", "dst hi", 32'(v), 32'h3C);
      reg_rd(4'h6, v); chk("R9", "len lo", 32'(v), 32'h81);
      reg_rd(4'h0, v); chk("R9", "go offset reads zero", 32'(v), 32'd0);
      reg_rd(4'hB, v); chk("R9", "unmapped reads zero", 32'(v), 32'd0);

      // window decode and command codes
      reg_wr(4'h2, 8'h11);
      host_op(2'd2, 16'hFD02, 8'h77);
      host_op(2'd3, 16'hFE02, 8'h66);
      host_op(2'd0, 16'hFE02, 8'h55);
      reg_rd(4'h2, v); chk("R1", "stray writes ignored", 32'(v), 32'h11);
      host_op(2'd1, 16'hFF01, 8'd0);
      chk("R1", "outside read holds rdata", 32'(host_rdata), 32'h11);

      // go value other than 1
      reg_wr(4'h0, 8'h02);
      reg_rd(4'h1, v); chk("R4", "go value 2 ignored", 32'(v), 32'd0);
      reg_wr(4'h0, 8'h03);
      reg_rd(4'h1, v); chk("R4", "go value 3 ignored", 32'(v), 32'd0);

      // directed length corners
      run_op(16'h0010, 16'h0C00, 16'd0,   1'b1, 1'b0);
      run_op(16'h0100, 16'h0C40, 16'd64,  1'b0, 1'b0);
      run_op(16'h0203, 16'h0C80, 16'd65,  1'b1, 1'b1);
      run_op(16'h0300, 16'h0CC0, 16'd128, 1'b0, 1'b0);

      // random operations
      for (int n = 0; n < 12; n++) begin
         logic [15:0] s, d, l;
         s = 16'($urandom_range(0, 16'h6FF));
         d = 16'h0C00 + 16'($urandom_range(0, 16'h3C0));
         l = 16'($urandom_range(0, 250));
         run_op(s, d, l, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule